// File: doc/BRIEF.md
# Banked Code Address Translator

This block sits between an 8051-class CPU's code-fetch path and an external serial flash used for execute-in-place. The 64 KB CPU code space is split unevenly. The bottom 16 KB (0x0000–0x3FFF) is a common region that always shows the first 16 KB of flash. The top 48 KB (0x4000–0xFFFF) is a window onto one of 21 banks. The banks lie end to end in flash, starting at flash address 0x4000, and each one is 0xC000 bytes long. Because that stride is not a power of two, the translation needs a real multiply-add rather than bit concatenation.

The bank shown in the window is held in a byte-wide register. Software loads it through a special-function-register style write strobe, and the new value takes effect for later fetches. Translation is combinational from the fetch address and the registered bank. If the window is addressed while the bank value is illegal, an error flag is raised and the flash address is forced to zero.

A second, independent combinational port runs the map in reverse for trace tooling. It takes a flash byte address and returns the bank number and the window offset in CPU space. It also flags addresses in the common area and addresses beyond the last bank.

Top module: `code_bank_xlate`

## Requirements
- R1: For a fetch address below 0x4000, flash_addr equals the fetch address, zero-extended, and range_err is 0. This holds whatever the bank register holds, including illegal values.
- R2: The bank register resets to 1. When bank_wr is high at a rising clock edge, the register takes bank_wdata, and translation uses the new bank from that edge on. When bank_wr is low, the register keeps its value.
- R3: For a fetch address A at or above 0x4000 with a legal bank B (1..21), flash_addr = 0x4000 + (B−1)·0xC000 + (A−0x4000), and range_err is 0.
- R4: For a fetch address at or above 0x4000 with bank 0 or a bank above 21, range_err is 1 and flash_addr is 0.
- R5: For trace_flash at or above 0x4000, trace_bank = ((trace_flash−0x4000) / 0xC000) + 1, trace_offset = ((trace_flash−0x4000) mod 0xC000) + 0x4000, and trace_common is 0.
- R6: For trace_flash below 0x4000, trace_common is 1, trace_bank is 0, trace_offset equals trace_flash, and trace_oob is 0.
- R7: trace_oob is 1 exactly when trace_flash is at or above 0x4000 and the computed bank exceeds 21. For example, trace_flash = 0x100000 gives trace_bank 22 and trace_oob 1.
- R8: For every legal bank and every window address, feeding flash_addr back into trace_flash returns the same bank and CPU address, with trace_oob 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_wr | input | 1 | Bank register write strobe |
| bank_wdata | input | 8 | Bank number to load |
| fetch_addr | input | 16 | CPU code-fetch address |
| flash_addr | output | 24 | Translated flash byte address |
| range_err | output | 1 | Window fetch with an illegal bank |
| trace_flash | input | 24 | Flash address to reverse-map |
| trace_bank | output | 8 | Bank number for trace_flash (0 in the common area) |
| trace_offset | output | 16 | CPU address for trace_flash |
| trace_common | output | 1 | trace_flash lies in the common area |
| trace_oob | output | 1 | trace_flash lies beyond the last bank |

## Verification
Only the bank register takes time. A write strobe sampled at one rising edge changes flash_addr and range_err straight after that edge. So the bench drives the strobe on a falling edge, lets one rising edge pass, and samples on the next falling edge. Every other result is combinational from the inputs. For those results the bench changes the inputs on a falling edge and reads the outputs a quarter period later, still well before the next rising edge. The round trip checks every legal bank at the lowest, highest and a middle window address.

// File: rtl/code_bank_xlate.sv
module code_bank_xlate #(
  parameter int CPU_AW    = 16,
  parameter int FLASH_AW  = 24,
  parameter int BANK_W    = 8,
  parameter int NUM_BANKS = 21,
  parameter int COMMON    = 16384
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bank_wr,
  input  logic [BANK_W-1:0]   bank_wdata,
  input  logic [CPU_AW-1:0]   fetch_addr,
  output logic [FLASH_AW-1:0] flash_addr,
  output logic                range_err,
  input  logic [FLASH_AW-1:0] trace_flash,
  output logic [BANK_W-1:0]   trace_bank,
  output logic [CPU_AW-1:0]   trace_offset,
  output logic                trace_common,
  output logic                trace_oob
);
  localparam int WIN = (1 << CPU_AW) - COMMON;
  localparam logic [FLASH_AW-1:0] COMMON_F = FLASH_AW'(COMMON);
  localparam logic [FLASH_AW-1:0] WIN_F    = FLASH_AW'(WIN);

  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk)
    if (!rst_n)       bank_q <= BANK_W'(1);
    else if (bank_wr) bank_q <= bank_wdata;

  // forward map
  logic                in_win, bank_ok;
  logic [FLASH_AW-1:0] win_base, win_off;

  assign in_win   = fetch_addr >= CPU_AW'(COMMON);
  assign bank_ok  = (bank_q != '0) && (bank_q <= BANK_W'(NUM_BANKS));
  assign win_base = COMMON_F + FLASH_AW'(bank_q - BANK_W'(1)) * WIN_F;
  assign win_off  = FLASH_AW'(fetch_addr) - COMMON_F;

  assign flash_addr = !in_win ? FLASH_AW'(fetch_addr) :
                      bank_ok ? win_base + win_off : '0;
  assign range_err  = in_win && !bank_ok;

  // reverse map
  logic [FLASH_AW-1:0] t_rel, t_q, t_r;

  assign trace_common = trace_flash < COMMON_F;
  assign t_rel        = trace_flash - COMMON_F;
  assign t_q          = t_rel / WIN_F;
  assign t_r          = t_rel % WIN_F;
  assign trace_bank   = trace_common ? '0 : BANK_W'(t_q) + BANK_W'(1);
  assign trace_offset = trace_common ? CPU_AW'(trace_flash) :
                        CPU_AW'(t_r) + CPU_AW'(COMMON);
  assign trace_oob    = !trace_common && (t_q >= FLASH_AW'(NUM_BANKS));

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |=> bank_q == $past(bank_wdata));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_wr |=> $stable(bank_q));
  p_common_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr < CPU_AW'(COMMON)) |-> (!range_err && flash_addr == FLASH_AW'(fetch_addr)));
  p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> flash_addr == '0);
  p_win_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && !range_err) |-> flash_addr >= COMMON_F);
  p_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_common |-> trace_offset >= CPU_AW'(COMMON));
  p_common_rev_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trace_common |-> (trace_bank == '0 && !trace_oob));
endmodule

// File: tb/sim_code_bank_xlate.sv
`timescale 1ns/1ps
module sim_code_bank_xlate;
  logic        clk = 0, rst_n = 0, bank_wr = 0;
  logic [7:0]  bank_wdata = 0;
  logic [15:0] fetch_addr = 0;
  logic [23:0] flash_addr, trace_flash = 0;
  logic        range_err, trace_common, trace_oob;
  logic [7:0]  trace_bank;
  logic [15:0] trace_offset;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  code_bank_xlate u0 (.clk, .rst_n, .bank_wr, .bank_wdata, .fetch_addr, .flash_addr,
    .range_err, .trace_flash, .trace_bank, .trace_offset, .trace_common, .trace_oob);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fwd(int b, int a);
    return 32'h4000 + (b - 1) * 32'hC000 + (a - 32'h4000);
  endfunction

  task automatic set_bank(logic [7:0] b);
    @(negedge clk); bank_wr = 1; bank_wdata = b;
    @(negedge clk); bank_wr = 0;
  endtask

  task automatic look(logic [15:0] a);
    fetch_addr = a; #1.25;
  endtask

  task automatic t_reset;
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1;
    look(16'h4000);
    chk("R2 reset bank", flash_addr, 32'h4000);
    chk("R2 reset err", range_err, 0);
  endtask

  task automatic t_common;
    set_bank(8'd7);
    look(16'h0000); chk("R1 low", flash_addr, 0);
    look(16'h3FFF); chk("R1 top", flash_addr, 32'h3FFF);
    set_bank(8'd0);
    look(16'h1234); chk("R1 bad bank addr", flash_addr, 32'h1234);
    chk("R1 bad bank err", range_err, 0);
  endtask

  task automatic t_window;
    set_bank(8'd3);
    look(16'h8FE2); chk("R3 bank3", flash_addr, 32'h20FE2);
    set_bank(8'd21);
    look(16'hFFFF); chk("R3 last byte", flash_addr, 32'hFFFFF);
    // hold: bank_wr low with different data must not change the bank
    @(negedge clk); bank_wdata = 8'd5; @(negedge clk);
    look(16'h4000); chk("R2 hold", flash_addr, fwd(21, 16'h4000));
    // write takes effect after the edge
    @(negedge clk); bank_wr = 1; bank_wdata = 8'd13; fetch_addr = 16'h6AAD; #1.25;
    chk("R2 before edge", flash_addr, fwd(21, 16'h6AAD));
    @(negedge clk); bank_wr = 0; #1.25;
    chk("R2 after edge", flash_addr, 32'h96AAD);
  endtask

  task automatic t_badbank;
    set_bank(8'd0); look(16'h4000);
    chk("R4 bank0 err", range_err, 1); chk("R4 bank0 addr", flash_addr, 0);
    set_bank(8'd22); look(16'hC000);
    chk("R4 bank22 err", range_err, 1); chk("R4 bank22 addr", flash_addr, 0);
    set_bank(8'd255); look(16'hFFFF);
    chk("R4 bank255 err", range_err, 1);
  endtask

  task automatic t_reverse;
    @(negedge clk); trace_flash = 24'h0B2C48; #1.25;
    chk("R5 bank", trace_bank, 15); chk("R5 offset", trace_offset, 16'hAC48);
    chk("R5 common", trace_common, 0);
    @(negedge clk); trace_flash = 24'h003E88; #1.25;
    chk("R6 common", trace_common, 1); chk("R6 bank", trace_bank, 0);
    chk("R6 offset", trace_offset, 16'h3E88); chk("R6 oob", trace_oob, 0);
    @(negedge clk); trace_flash = 24'h0FFFFF; #1.25;
    chk("R7 last legal", trace_oob, 0);
    @(negedge clk); trace_flash = 24'h100000; #1.25;
    chk("R7 oob", trace_oob, 1); chk("R7 bank22", trace_bank, 22);
  endtask

  task automatic t_roundtrip;
    for (int b = 1; b <= 21; b++) begin
      set_bank(b[7:0]);
      for (int k = 0; k < 3; k++) begin
        logic [15:0] a;
        a = (k == 0) ? 16'h4000 : (k == 1) ? 16'hFFFF : 16'h9A5B;
        @(negedge clk); fetch_addr = a; #1.25;
        chk("R3 fwd", flash_addr, fwd(b, a));
        trace_flash = flash_addr; #1.25;
        chk("R8 bank", trace_bank, b);
        chk("R8 offset", trace_offset, a);
        chk("R8 oob", trace_oob, 0);
      end
    end
  endtask

  initial begin
    t_reset; t_common; t_window; t_badbank; t_reverse; t_roundtrip;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule